// File: doc/BRIEF.md
# Serial Configuration Word Receiver

This block takes a 16-bit control word from a write-only three-wire serial link (an active-low select, a serial clock and a data line) and presents it to the rest of the chip as registered configuration outputs. Data bits enter a shift register, most significant bit first, on each falling serial-clock edge while the select is low. Only when the select returns high, and only if exactly 16 bits were clocked, is the word handed to the output side.

The serial pins form their own clock domain. A captured word is passed to the system clock domain through a toggle handshake with a two-stage synchroniser. The system-side register then updates. Bit 15 drives a gain-reduction control output. The full word stays visible for monitoring. Two sticky flags report abnormal traffic: one for a word whose reserved bits (13 down to 0) are not the mandatory pattern, and one for a transfer with the wrong bit count.

Top module: `cfgrx_top`

## Requirements
- R1: While and after reset, `cfg_word` reads 0x0714, `gain_red` is 0, and `bad_word` and `frame_err` are 0.
- R2: A transfer of exactly 16 falling `sclk` edges with `cs_n` low, followed by a rising `cs_n`, loads the word into `cfg_word`. The first bit clocked lands in bit 15.
- R3: Before the rising edge of `cs_n`, `cfg_word` keeps its previous value, even after all 16 bits are shifted in.
- R4: `sclk` edges while `cs_n` is high shift nothing and count nothing. A later 16-bit transfer still loads its exact word.
- R5: `gain_red` equals bit 15 of the latched word: 1 requests reduced gain.
- R6: A latched word whose bits 13..0 differ from 0x0714's bits 13..0 (ones at 10, 9, 8, 4 and 2, zeros elsewhere) sets `bad_word`. The word is still loaded into `cfg_word`.
- R7: `bad_word` and `frame_err` stay set until reset, whatever words follow.
- R8: A rising `cs_n` after any count of falling `sclk` edges other than 16 (including 0, 15 and 17) leaves `cfg_word` unchanged and sets `frame_err`.
- R9: The output register updates on the third rising `clk` edge after the rising `cs_n`, and not on the first.
- R10: Bit 14 has no control function: a word with bit 14 set and the correct reserved pattern is loaded without setting `bad_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset: synchronous on the system side, asynchronous on the serial side |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| cs_n | input | 1 | Active-low select; its rising edge commits the transfer |
| sdi | input | 1 | Serial data, most significant bit first |
| cfg_word | output | 16 | Latched configuration word |
| gain_red | output | 1 | Gain-reduction control (bit 15 of the word) |
| bad_word | output | 1 | Sticky flag: a latched word had the wrong reserved bits |
| frame_err | output | 1 | Sticky flag: a transfer had the wrong bit count |

## Verification
The bench builds the block with its defaults: a 16-bit word, a 5-bit saturating edge counter and a two-stage synchroniser. With the two-stage synchroniser, the update falls on a fixed third system edge, so the bench can sample on both sides of it. The 5-bit counter lets overlong frames of 17 bits be told apart from exact ones, and short frames of 0 and 15 bits are driven as well. The stimulus table carries sticky flags across rows, so that flag persistence and the loading of illegal words are both observed at the ports.

// File: rtl/cfgrx_pkg.sv
// Shared constants of the serial configuration receiver.
// Assumes a fixed-length control word with a fixed reserved-bit pattern.
package cfgrx_pkg;
    localparam int          CFG_W    = 16;
    localparam int          GAIN_BIT = 15;
    localparam int          CNT_W    = $clog2(CFG_W) + 1;
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 16'h0714;
    localparam logic [CFG_W-1:0] RSV_MASK    = 16'h3FFF;
    localparam logic [CFG_W-1:0] RSV_VALUE   = CFG_DEFAULT & RSV_MASK;
endpackage

// File: rtl/cfgrx_shift.sv
// Serial-domain front end: shifts data on falling sclk while cs_n is low,
// counts the edges, and on rising cs_n either captures the word and toggles
// a request, or toggles a framing-error event.
// Assumes rising cs_n is the only commit event and that sclk stays idle
// long enough after it for the system side to copy hold_word.
module cfgrx_shift
    import cfgrx_pkg::*;
(
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             sdi,
    output logic [CFG_W-1:0] hold_word,
    output logic             req_tgl,
    output logic             ferr_tgl
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CFG_W);

    logic [CFG_W-1:0] sreg;
    logic [CNT_W-1:0] cnt;

    // Shift data MSB first on falling sclk while selected.
    always_ff @(negedge sclk) begin
        if (!cs_n) begin
            sreg <= {sreg[CFG_W-2:0], sdi};
        end
    end

    // Count falling edges in a frame; cleared whenever the select is high.
    always_ff @(negedge sclk or posedge cs_n or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cs_n) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Commit on rising select: exact count captures, other counts report.
    always_ff @(posedge cs_n or negedge rst_n) begin
        if (!rst_n) begin
            hold_word <= CFG_DEFAULT;
            req_tgl   <= 1'b0;
            ferr_tgl  <= 1'b0;
        end else if (cnt == CNT_FULL) begin
            hold_word <= sreg;
            req_tgl   <= ~req_tgl;
        end else begin
            ferr_tgl  <= ~ferr_tgl;
        end
    end
endmodule

// File: rtl/cfgrx_sync.sv
// Toggle synchroniser: carries a level toggle into clk through STAGES flops
// and emits a one-cycle pulse per toggle.
// Assumes toggles are spaced well beyond STAGES+1 clk cycles.
module cfgrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic [STAGES-1:0] st;
    logic              last;

    // First stage samples the foreign toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= 1'b0;
        else        st[0] <= tgl_in;
    end

    // Remaining stages of the chain.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) st[g] <= 1'b0;
            else        st[g] <= st[g-1];
        end
    end

    // Remember the settled level to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= st[STAGES-1];
    end

    assign pulse = st[STAGES-1] ^ last;
endmodule

// File: rtl/cfgrx_latch.sv
// System-side output register: loads the captured word on an update pulse,
// checks its reserved bits and keeps the sticky error flags.
// Assumes hold_word is stable whenever upd is high.
module cfgrx_latch
    import cfgrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             ferr,
    input  logic [CFG_W-1:0] hold_word,
    output logic [CFG_W-1:0] cfg_word,
    output logic             bad_word,
    output logic             frame_err
);
    logic rsv_wrong;

    // Compare the reserved field against its mandatory pattern.
    always_comb begin
        rsv_wrong = (hold_word & RSV_MASK) != RSV_VALUE;
    end

    // Load the word and flag illegal contents; flags are sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_word  <= CFG_DEFAULT;
            bad_word  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            if (upd) begin
                cfg_word <= hold_word;
                if (rsv_wrong) bad_word <= 1'b1;
            end
            if (ferr) frame_err <= 1'b1;
        end
    end
endmodule

// File: rtl/cfgrx_top.sv
// Serial configuration receiver top: serial front end, two toggle
// synchronisers and the system-side output register.
// Assumes sclk and cs_n are asynchronous to clk.
module cfgrx_top
    import cfgrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             sdi,
    output logic [CFG_W-1:0] cfg_word,
    output logic             gain_red,
    output logic             bad_word,
    output logic             frame_err
);
    logic [CFG_W-1:0] hold_word;
    logic             req_tgl;
    logic             ferr_tgl;
    logic             upd_pulse;
    logic             ferr_pulse;

    cfgrx_shift u_shift (
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .hold_word(hold_word),
        .req_tgl  (req_tgl),
        .ferr_tgl (ferr_tgl)
    );

    cfgrx_sync #(.STAGES(SYNC_STAGES)) u_sync_upd (
        .clk   (clk),
        .rst_n (rst_n),
        .tgl_in(req_tgl),
        .pulse (upd_pulse)
    );

    cfgrx_sync #(.STAGES(SYNC_STAGES)) u_sync_ferr (
        .clk   (clk),
        .rst_n (rst_n),
        .tgl_in(ferr_tgl),
        .pulse (ferr_pulse)
    );

    cfgrx_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd_pulse),
        .ferr     (ferr_pulse),
        .hold_word(hold_word),
        .cfg_word (cfg_word),
        .bad_word (bad_word),
        .frame_err(frame_err)
    );

    assign gain_red = cfg_word[GAIN_BIT];
endmodule

// File: rtl/cfgrx_chk.sv
// Property checker for cfgrx_top, attached by bind.
// Assumes the system reset is synchronous and active low.
module cfgrx_chk
    import cfgrx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             upd,
    input logic [CFG_W-1:0] cfg_word,
    input logic             bad_word,
    input logic             frame_err
);
    // R1
    reset_default_chk: assert property (@(posedge clk)
        !rst_n |=> (cfg_word == CFG_DEFAULT && !bad_word && !frame_err));

    // R3
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(cfg_word));

    // R6
    bad_with_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_word) |-> $past(upd));

    // R7
    bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_word |=> bad_word);

    // R7
    ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
endmodule

bind cfgrx_top cfgrx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (upd_pulse),
    .cfg_word (cfg_word),
    .bad_word (bad_word),
    .frame_err(frame_err)
);

// File: tb/cfgrx_top_tb.sv
module cfgrx_top_tb;
    localparam int CLK_P = 10;
    localparam int HALF  = 10;

    typedef struct packed {
        logic [15:0] w;
        logic [4:0]  n;
        logic [15:0] ew;
        logic        eb;
        logic        ef;
    } vec_t;

    // Cumulative rows: flags carry over from row to row.
    localparam vec_t VECS [7] = '{
        '{16'h8714, 5'd16, 16'h8714, 1'b0, 1'b0},
        '{16'h4714, 5'd16, 16'h4714, 1'b0, 1'b0},
        '{16'h0714, 5'd16, 16'h0714, 1'b0, 1'b0},
        '{16'hABCD, 5'd15, 16'h0714, 1'b0, 1'b1},
        '{16'h8714, 5'd17, 16'h0714, 1'b0, 1'b1},
        '{16'h0715, 5'd16, 16'h0715, 1'b1, 1'b1},
        '{16'h8714, 5'd16, 16'h8714, 1'b1, 1'b1}
    };

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk  = 1'b1;
    logic        cs_n  = 1'b1;
    logic        sdi   = 1'b0;
    logic [15:0] cfg_word;
    logic        gain_red;
    logic        bad_word;
    logic        frame_err;

    int checks   = 0;
    int failures = 0;
    bit ended    = 0;

    cfgrx_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .cfg_word (cfg_word),
        .gain_red (gain_red),
        .bad_word (bad_word),
        .frame_err(frame_err)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Clock n bits of w (MSB of the n-bit field first) with cs_n low.
    task automatic shift_bits(input logic [31:0] w, input int n);
        cs_n = 1'b0;
        #HALF;
        for (int i = n - 1; i >= 0; i--) begin
            sdi = w[i];
            #HALF; sclk = 1'b0;
            #HALF; sclk = 1'b1;
        end
        #HALF;
    endtask

    task automatic commit_and_wait();
        cs_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 100000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: values held during reset
        check("R1 word in reset", cfg_word, 16'h0714);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 word", cfg_word, 16'h0714);
        check("R1 flags", {13'd0, gain_red, bad_word, frame_err}, 16'h0);

        // Table walk: R2 R5 R6 R7 R8 R10
        foreach (VECS[k]) begin
            shift_bits({16'h0, VECS[k].w} | (VECS[k].n == 5'd17 ? 32'h10000 : 32'h0), int'(VECS[k].n));
            commit_and_wait();
            check($sformatf("R2/R8 row%0d word", k), cfg_word, VECS[k].ew);
            check($sformatf("R5 row%0d gain", k), {15'd0, gain_red}, {15'd0, VECS[k].ew[15]});
            check($sformatf("R6/R7/R10 row%0d bad", k), {15'd0, bad_word}, {15'd0, VECS[k].eb});
            check($sformatf("R7/R8 row%0d ferr", k), {15'd0, frame_err}, {15'd0, VECS[k].ef});
        end

        // R1: reset clears word and sticky flags
        do_reset();
        @(posedge clk); #1;
        check("R1 after re-reset word", cfg_word, 16'h0714);
        check("R1 after re-reset flags", {14'd0, bad_word, frame_err}, 16'h0);

        // R3: all 16 bits in, select still low, output unchanged
        shift_bits(32'h0000_C714, 16);
        repeat (5) @(posedge clk); #1;
        check("R3 before commit", cfg_word, 16'h0714);
        // R9: not yet after the first clk edge, present after the third
        cs_n = 1'b1;
        @(posedge clk); #1;
        check("R9 first edge", cfg_word, 16'h0714);
        @(posedge clk); @(posedge clk); #1;
        check("R9 third edge", cfg_word, 16'hC714);

        // R4: idle sclk activity with select high has no effect
        sdi = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #HALF; sclk = 1'b0;
            #HALF; sclk = 1'b1;
        end
        repeat (5) @(posedge clk); #1;
        check("R4 idle word", cfg_word, 16'hC714);
        check("R4 idle ferr", {15'd0, frame_err}, 16'h0);
        shift_bits(32'h0000_0714, 16);
        commit_and_wait();
        check("R4 exact word after idle clocks", cfg_word, 16'h0714);

        // R8: select pulse with no clocks at all
        cs_n = 1'b0;
        #(2 * HALF);
        commit_and_wait();
        check("R8 zero-bit word", cfg_word, 16'h0714);
        check("R8 zero-bit ferr", {15'd0, frame_err}, 16'h1);

        finish_run();
    end
endmodule